// File: doc/BRIEF.md
# Three-Level Page Table Walker

This unit turns a 64-bit virtual address into a physical page address, a set of granted access rights and a fault code. It serves one request at a time. First it classifies the address: a badly sign-extended address is refused at once, and a direct-mapped kernel superpage is translated without touching memory. Any other address starts a walk through three levels of 64-bit page table entries. The walk begins at the table base supplied with the request, and each entry is fetched through a valid/ready read port with one read in flight.

The two upper levels must each hold a valid, kernel-readable entry. The leaf entry grants read and exec through a read enable, and write through a write enable. Each enable is chosen by the requesting mode. The leaf's fault-on-access bits then take rights away again. The caller sees a single-cycle response pulse that carries the result.

Top module: `pw_walker`

## Requirements
- R1: If any of virtual address bits 63 down to VA_BITS (43) differs from bit 63, the response is fault code 1 (access violation), it arrives in the cycle after acceptance, and no memory read is issued.
- R2: A canonical address with bit 63 set and bits 42:41 equal to binary 10 is a superpage. In kernel mode (mode 0) it returns fault code 0, physical address equal to the low 40 address bits and rights 3'b111, with no memory read.
- R3: A superpage address requested in user mode (mode 1) returns fault code 1 with no memory read.
- R4: The first entry is read at the table base plus 8 times virtual bits 42:33, the second at its table base plus 8 times bits 32:23, and the leaf at its table base plus 8 times bits 22:13.
- R5: The next table base and the returned physical page are both entry bits 63:32 shifted left by 13.
- R6: At level 1 or level 2, an entry with bit 0 (valid) clear ends the walk with fault code 2 (not valid), and no further read is issued.
- R7: At level 1 or level 2, a valid entry with bit 8 (kernel read) clear ends the walk with fault code 1, in either mode.
- R8: A leaf with bit 0 clear gives fault code 2.
- R9: At the leaf, bit 8+mode grants read (rights bit 0) and exec (rights bit 2), and bit 12+mode grants write (rights bit 1).
- R10: When the requested rights are nonzero and none of them is granted by R9, the fault is code 1, even if fault-on bits are set.
- R11: Leaf bits 1, 2 and 3 remove read, write and exec respectively. If no requested right remains, the fault is code 5 when exec was requested, else code 4 when write was requested, else code 3. A request keeps going when at least one requested right survives.
- R12: A probe (requested rights 0) that reaches a valid leaf returns fault code 0 with the physical page and the masked rights.
- R13: The read request holds valid and address stable until ready. No new read is issued while one is outstanding. req_ready is high only when idle. rsp_valid lasts one cycle, and on any fault rsp_phys and rsp_prot are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address |
| req_mode | input | 1 | 0 kernel, 1 user |
| req_need | input | 3 | Requested rights: bit0 read, bit1 write, bit2 exec |
| req_tbase | input | PA_W (45) | Physical base of the level-1 table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W (45) | Physical address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Page table entry |
| rsp_valid | output | 1 | Result pulse |
| rsp_phys | output | PA_W (45) | Physical page address |
| rsp_prot | output | 3 | Granted rights |
| rsp_fault | output | 3 | 0 none, 1 access violation, 2 not valid, 3 read, 4 write, 5 exec fault |

## Verification
At the leaf, two checks are judged in the same cycle: the privilege grant and the fault-on masking. The bench places leaves where both bear on one request. One leaf has fault-on-read set and no enable, and must give an access violation rather than a read fault. Another grants everything and sets all fault-on bits. Against that leaf, requests for exec with write, for write alone and for read alone must give the exec, write and read faults in that priority. A leaf with only write masked, asked for read and write, must succeed because read survives. Memory-ready stalls fall on the same cycles as a new read's address, and the address must hold until it is accepted.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_ACV  = 3'd1,
    FLT_TNV  = 3'd2,
    FLT_FOR  = 3'd3,
    FLT_FOW  = 3'd4,
    FLT_FOE  = 3'd5
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1,
    ST_L2,
    ST_L3,
    ST_CHECK,
    ST_DONE
  } walk_st_e;

  localparam int IDX_W     = 10;
  localparam int LEVELS    = 3;
  localparam int ENT_SHIFT = 3;
  localparam int PFN_W     = 32;

  localparam int RT_R = 0;
  localparam int RT_W = 1;
  localparam int RT_X = 2;

  // Priority among fault-on outcomes: exec wins, then write, then read.
  function automatic fault_e fo_pick(input logic [2:0] need);
    if (need[RT_X])      return FLT_FOE;
    else if (need[RT_W]) return FLT_FOW;
    else                 return FLT_FOR;
  endfunction

  // Page base from a frame number.
  function automatic logic [PFN_W+12:0] pfn_to_base13(input logic [PFN_W-1:0] pfn);
    return {pfn, 13'd0};
  endfunction

endpackage

// File: rtl/pw_va_class.sv
module pw_va_class #(
  parameter int VA_BITS = 43,
  parameter int SP_BITS = 40,
  parameter int PA_W    = 45
) (
  input  logic [63:0]     va,
  output logic            canon_ok,
  output logic            super_hit,
  output logic [PA_W-1:0] sp_phys
);
  localparam int EXT_W = 64 - VA_BITS;

  function automatic logic is_canon(input logic [63:0] a);
    return a[63:VA_BITS] == {EXT_W{a[63]}};
  endfunction

  function automatic logic is_super(input logic [63:0] a);
    return a[63] && (a[VA_BITS-1 -: 2] == 2'b10);
  endfunction

  assign canon_ok  = is_canon(va);
  assign super_hit = is_super(va);
  assign sp_phys   = PA_W'(va[SP_BITS-1:0]);
endmodule

// File: rtl/pw_index_sel.sv
module pw_index_sel
  import pw_pkg::*;
#(
  parameter int PA_W = 45,
  localparam int VIDX_W = LEVELS * IDX_W
) (
  input  logic [VIDX_W-1:0] vidx,
  input  logic [1:0]        lvl,
  input  logic [PA_W-1:0]   base,
  output logic [PA_W-1:0]   ent_addr
);
  logic [IDX_W-1:0] slot [LEVELS];
  logic [IDX_W-1:0] idx_c;

  // slot[0] is the level-1 index (highest bits), slot[LEVELS-1] the leaf.
  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_slot
      assign slot[g] = vidx[(LEVELS-1-g)*IDX_W +: IDX_W];
    end
  endgenerate

  always_comb begin
    idx_c = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (lvl == k[1:0]) idx_c = slot[k];
    end
  end

  function automatic logic [PA_W-1:0] ent_at(input logic [PA_W-1:0] b,
                                             input logic [IDX_W-1:0] i);
    return b + PA_W'({i, {ENT_SHIFT{1'b0}}});
  endfunction

  assign ent_addr = ent_at(base, idx_c);
endmodule

// File: rtl/pw_dir_check.sv
module pw_dir_check
  import pw_pkg::*;
#(
  parameter int PG_BITS = 13,
  localparam int PA_W = PFN_W + PG_BITS
) (
  input  logic             ent_valid,
  input  logic             ent_kre,
  input  logic [PFN_W-1:0] ent_pfn,
  output fault_e           fault,
  output logic [PA_W-1:0]  next_base
);
  always_comb begin
    if (!ent_valid)    fault = FLT_TNV;
    else if (!ent_kre) fault = FLT_ACV;
    else               fault = FLT_NONE;
  end

  assign next_base = {ent_pfn, {PG_BITS{1'b0}}};
endmodule

// File: rtl/pw_leaf_check.sv
module pw_leaf_check
  import pw_pkg::*;
#(
  parameter int PG_BITS = 13,
  localparam int PA_W = PFN_W + PG_BITS
) (
  input  logic             lf_valid,
  input  logic [1:0]       lf_re,
  input  logic [1:0]       lf_we,
  input  logic [2:0]       lf_fo,
  input  logic [PFN_W-1:0] lf_pfn,
  input  logic             mode,
  input  logic [2:0]       need,
  output fault_e           fault,
  output logic [2:0]       prot,
  output logic [PA_W-1:0]  phys
);
  logic       rd_en, wr_en;
  logic [2:0] granted, kept;
  fault_e     f_c;

  assign rd_en   = lf_re[mode];
  assign wr_en   = lf_we[mode];
  assign granted = {rd_en, wr_en, rd_en};
  // fault-on bits are ordered exec, write, read, same as the rights vector
  assign kept    = granted & ~lf_fo;

  always_comb begin
    if (!lf_valid)                                f_c = FLT_TNV;
    else if (need != 3'b000 && (granted & need) == 3'b000) f_c = FLT_ACV;
    else if (need != 3'b000 && (kept & need) == 3'b000)    f_c = fo_pick(need);
    else                                          f_c = FLT_NONE;
  end

  assign fault = f_c;
  assign prot  = (f_c == FLT_NONE) ? kept : 3'b000;
  assign phys  = (f_c == FLT_NONE) ? {lf_pfn, {PG_BITS{1'b0}}} : '0;
endmodule

// File: rtl/pw_walker.sv
module pw_walker
  import pw_pkg::*;
#(
  parameter int VA_BITS = 43,
  parameter int PG_BITS = 13,
  parameter int SP_BITS = 40,
  localparam int PA_W = PFN_W + PG_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_vaddr,
  input  logic            req_mode,
  input  logic [2:0]      req_need,
  input  logic [PA_W-1:0] req_tbase,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_phys,
  output logic [2:0]      rsp_prot,
  output logic [2:0]      rsp_fault
);
  localparam int VIDX_W = LEVELS * IDX_W;

  walk_st_e          st_q;
  logic              pend_q;
  logic [PA_W-1:0]   base_q;
  logic [VIDX_W-1:0] vidx_q;
  logic              mode_q;
  logic [2:0]        need_q;

  logic              lf_valid_q;
  logic [1:0]        lf_re_q, lf_we_q;
  logic [2:0]        lf_fo_q;
  logic [PFN_W-1:0]  lf_pfn_q;

  fault_e            res_fault_q;
  logic [PA_W-1:0]   res_phys_q;
  logic [2:0]        res_prot_q;

  // named events for the checker
  logic              accept, rd_fire, rd_back, rd_pending, in_walk;
  logic              canon_ok, super_hit;
  logic [PA_W-1:0]   sp_phys;
  logic [1:0]        lvl_c;

  fault_e            dir_fault;
  logic [PA_W-1:0]   dir_next;
  fault_e            leaf_fault;
  logic [2:0]        leaf_prot;
  logic [PA_W-1:0]   leaf_phys;

  assign req_ready  = (st_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign in_walk    = (st_q == ST_L1) || (st_q == ST_L2) || (st_q == ST_L3);
  assign rd_pending = pend_q;
  assign mem_req_valid = in_walk && !pend_q;
  assign rd_fire    = mem_req_valid && mem_req_ready;
  assign rd_back    = pend_q && mem_rsp_valid;

  always_comb begin
    unique case (st_q)
      ST_L2:   lvl_c = 2'd1;
      ST_L3:   lvl_c = 2'd2;
      default: lvl_c = 2'd0;
    endcase
  end

  pw_va_class #(.VA_BITS(VA_BITS), .SP_BITS(SP_BITS), .PA_W(PA_W)) u_class (
    .va        (req_vaddr),
    .canon_ok  (canon_ok),
    .super_hit (super_hit),
    .sp_phys   (sp_phys)
  );

  pw_index_sel #(.PA_W(PA_W)) u_isel (
    .vidx     (vidx_q),
    .lvl      (lvl_c),
    .base     (base_q),
    .ent_addr (mem_req_addr)
  );

  pw_dir_check #(.PG_BITS(PG_BITS)) u_dir (
    .ent_valid (mem_rsp_data[0]),
    .ent_kre   (mem_rsp_data[8]),
    .ent_pfn   (mem_rsp_data[63:32]),
    .fault     (dir_fault),
    .next_base (dir_next)
  );

  pw_leaf_check #(.PG_BITS(PG_BITS)) u_leaf (
    .lf_valid (lf_valid_q),
    .lf_re    (lf_re_q),
    .lf_we    (lf_we_q),
    .lf_fo    (lf_fo_q),
    .lf_pfn   (lf_pfn_q),
    .mode     (mode_q),
    .need     (need_q),
    .fault    (leaf_fault),
    .prot     (leaf_prot),
    .phys     (leaf_phys)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      pend_q      <= 1'b0;
      base_q      <= '0;
      vidx_q      <= '0;
      mode_q      <= 1'b0;
      need_q      <= 3'b000;
      lf_valid_q  <= 1'b0;
      lf_re_q     <= 2'b00;
      lf_we_q     <= 2'b00;
      lf_fo_q     <= 3'b000;
      lf_pfn_q    <= '0;
      res_fault_q <= FLT_NONE;
      res_phys_q  <= '0;
      res_prot_q  <= 3'b000;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            vidx_q <= req_vaddr[PG_BITS +: VIDX_W];
            mode_q <= req_mode;
            need_q <= req_need;
            base_q <= req_tbase;
            if (!canon_ok) begin
              res_fault_q <= FLT_ACV;
              res_phys_q  <= '0;
              res_prot_q  <= 3'b000;
              st_q        <= ST_DONE;
            end else if (super_hit) begin
              res_fault_q <= req_mode ? FLT_ACV : FLT_NONE;
              res_phys_q  <= req_mode ? '0 : sp_phys;
              res_prot_q  <= req_mode ? 3'b000 : 3'b111;
              st_q        <= ST_DONE;
            end else begin
              st_q <= ST_L1;
            end
          end
        end
        ST_L1, ST_L2, ST_L3: begin
          if (rd_fire) pend_q <= 1'b1;
          if (rd_back) begin
            pend_q <= 1'b0;
            if (st_q == ST_L3) begin
              lf_valid_q <= mem_rsp_data[0];
              lf_fo_q    <= mem_rsp_data[3:1];
              lf_re_q    <= mem_rsp_data[9:8];
              lf_we_q    <= mem_rsp_data[13:12];
              lf_pfn_q   <= mem_rsp_data[63:32];
              st_q       <= ST_CHECK;
            end else if (dir_fault != FLT_NONE) begin
              res_fault_q <= dir_fault;
              res_phys_q  <= '0;
              res_prot_q  <= 3'b000;
              st_q        <= ST_DONE;
            end else begin
              base_q <= dir_next;
              st_q   <= (st_q == ST_L1) ? ST_L2 : ST_L3;
            end
          end
        end
        ST_CHECK: begin
          res_fault_q <= leaf_fault;
          res_phys_q  <= leaf_phys;
          res_prot_q  <= leaf_prot;
          st_q        <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = (st_q == ST_DONE);
  assign rsp_fault = res_fault_q;
  assign rsp_phys  = res_phys_q;
  assign rsp_prot  = res_prot_q;
endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk #(
  parameter int PA_W = 45
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic            canon_ok,
  input logic            super_hit,
  input logic            req_mode,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            rd_pending,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_phys,
  input logic [2:0]      rsp_prot,
  input logic [2:0]      rsp_fault
);
  p_noncanon_acv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !canon_ok |=> rsp_valid && rsp_fault == 3'd1 && !mem_req_valid);

  p_super_kernel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && canon_ok && super_hit && !req_mode |=>
      rsp_valid && rsp_fault == 3'd0 && rsp_prot == 3'b111 && !mem_req_valid);

  p_super_user_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && canon_ok && super_hit && req_mode |=> rsp_valid && rsp_fault == 3'd1);

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_one_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pending |-> !mem_req_valid);

  p_fault_clean_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 3'd0 |-> rsp_phys == '0 && rsp_prot == 3'b000);

  p_rsp_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind pw_walker pw_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .accept        (accept),
  .canon_ok      (canon_ok),
  .super_hit     (super_hit),
  .req_mode      (req_mode),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .rd_pending    (rd_pending),
  .rsp_valid     (rsp_valid),
  .rsp_phys      (rsp_phys),
  .rsp_prot      (rsp_prot),
  .rsp_fault     (rsp_fault)
);

// File: tb/tb_pw_walker.sv
`timescale 1ns/1ps
module tb_pw_walker;
  localparam int PA_W = 45;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic [63:0]     req_vaddr;
  logic            req_mode;
  logic [2:0]      req_need;
  logic [PA_W-1:0] req_tbase;
  logic            mem_req_valid;
  logic            mem_req_ready;
  logic [PA_W-1:0] mem_req_addr;
  logic            mem_rsp_valid;
  logic [63:0]     mem_rsp_data;
  logic            rsp_valid;
  logic [PA_W-1:0] rsp_phys;
  logic [2:0]      rsp_prot;
  logic [2:0]      rsp_fault;

  always #2 clk = ~clk;

  pw_walker dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_mode(req_mode), .req_need(req_need), .req_tbase(req_tbase),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_phys(rsp_phys),
    .rsp_prot(rsp_prot), .rsp_fault(rsp_fault)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // page table memory, keyed by physical address
  logic [63:0] pmem [longint unsigned];
  int          rd_cnt;
  logic [PA_W-1:0] rd_log [4];
  bit          fire;
  logic [PA_W-1:0] fire_addr;
  int          stall_cnt;

  logic [PA_W-1:0] got_phys;
  logic [2:0]      got_prot, got_fault;

  localparam logic [PA_W-1:0] TB0 = 45'h2000;

  function automatic logic [63:0] mkpte(input logic [31:0] pfn, input logic [15:0] fl);
    return {pfn, 16'h0000, fl};
  endfunction

  function automatic logic [63:0] mkva(input int i1, input int i2, input int i3);
    logic [63:0] v;
    v = 64'd0;
    v[42:33] = 10'(i1);
    v[32:23] = 10'(i2);
    v[22:13] = 10'(i3);
    return v;
  endfunction

  function automatic logic [PA_W-1:0] page(input int pfn);
    return PA_W'(64'(pfn) * 64'd8192);
  endfunction

  function automatic logic [63:0] lookup(input logic [PA_W-1:0] a);
    longint unsigned k;
    k = 64'(a);
    if (pmem.exists(k)) return pmem[k];
    return 64'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: ready stalls every third cycle, data one cycle after accept
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 64'd0;
    fire = 1'b0;
    fire_addr = '0;
    stall_cnt = 0;
    rd_cnt = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (fire) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = lookup(fire_addr);
        fire = 1'b0;
      end
      stall_cnt++;
      mem_req_ready = (stall_cnt % 3) != 0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        fire = 1'b1;
        fire_addr = mem_req_addr;
        if (rd_cnt < 4) rd_log[rd_cnt] = mem_req_addr;
        rd_cnt++;
      end
    end
  end

  task automatic walk(input logic [63:0] va, input logic mode, input logic [2:0] need);
    int n;
    @(negedge clk);
    rd_cnt    = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    req_mode  = mode;
    req_need  = need;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    got_phys  = rsp_phys;
    got_prot  = rsp_prot;
    got_fault = rsp_fault;
    if (!rsp_valid) chk(1'b0, "R13 no response", 0, 1);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R13 reset ready", 64'(req_ready), 1);
    chk(mem_req_valid == 1'b0 && rsp_valid == 1'b0, "R13 reset outputs",
        64'({mem_req_valid, rsp_valid}), 0);
  endtask

  task automatic t_noncanon();
    walk(64'h0000_0800_0000_0000, 1'b0, 3'b001);
    chk(got_fault == 3'd1, "R1 fault", 64'(got_fault), 1);
    chk(rd_cnt == 0, "R1 no reads", 64'(rd_cnt), 0);
  endtask

  task automatic t_super();
    walk(64'hFFFF_FC12_3456_789A, 1'b0, 3'b010);
    chk(got_fault == 3'd0 && got_prot == 3'b111, "R2 fault/prot",
        64'({got_fault, got_prot}), 64'h7);
    chk(got_phys == 45'h12_3456_789A, "R2 phys", 64'(got_phys), 64'h12_3456_789A);
    chk(rd_cnt == 0, "R2 no reads", 64'(rd_cnt), 0);
    walk(64'hFFFF_FC12_3456_789A, 1'b1, 3'b001);
    chk(got_fault == 3'd1 && rd_cnt == 0, "R3 user superpage",
        64'({got_fault, 8'(rd_cnt)}), 64'h100);
  endtask

  task automatic t_neg_walk();
    // canonical negative address that is not a superpage: walks, level-1 index 0x300
    walk(64'hFFFF_FE00_0000_0000, 1'b0, 3'b001);
    chk(got_fault == 3'd2, "R6 level1 invalid", 64'(got_fault), 2);
    chk(rd_cnt == 1 && rd_log[0] == TB0 + 45'(10'h300 * 8), "R4 level1 addr",
        64'(rd_log[0]), 64'(TB0 + 45'(10'h300 * 8)));
  endtask

  task automatic t_full_read();
    walk(mkva(1, 1, 1), 1'b0, 3'b001);
    chk(got_fault == 3'd0 && got_prot == 3'b101, "R9 kernel read grant",
        64'({got_fault, got_prot}), 64'h5);
    chk(got_phys == page(32'h1001), "R5 phys", 64'(got_phys), 64'(page(32'h1001)));
    chk(rd_cnt == 3 && rd_log[0] == TB0 + 8 && rd_log[1] == page(2) + 8 &&
        rd_log[2] == page(3) + 8, "R4 entry addresses", 64'(rd_log[2]),
        64'(page(3) + 8));
  endtask

  task automatic t_user_modes();
    walk(mkva(1, 1, 1), 1'b1, 3'b001);
    chk(got_fault == 3'd1, "R10 user without enable", 64'(got_fault), 1);
    walk(mkva(1, 1, 3), 1'b1, 3'b010);
    chk(got_fault == 3'd0 && got_prot == 3'b111, "R9 user write grant",
        64'({got_fault, got_prot}), 64'h7);
    walk(mkva(1, 1, 3), 1'b0, 3'b001);
    chk(got_fault == 3'd1, "R9 kernel on user-only leaf", 64'(got_fault), 1);
  endtask

  task automatic t_dir_faults();
    walk(mkva(5, 1, 1), 1'b0, 3'b001);
    chk(got_fault == 3'd2 && rd_cnt == 2, "R6 level2 invalid",
        64'({got_fault, 8'(rd_cnt)}), 64'h202);
    walk(mkva(6, 1, 1), 1'b1, 3'b001);
    chk(got_fault == 3'd1 && rd_cnt == 1, "R7 level1 no kernel read",
        64'({got_fault, 8'(rd_cnt)}), 64'h101);
  endtask

  task automatic t_leaf_invalid();
    walk(mkva(1, 1, 2), 1'b0, 3'b001);
    chk(got_fault == 3'd2, "R8 leaf invalid", 64'(got_fault), 2);
    walk(mkva(1, 1, 2), 1'b0, 3'b000);
    chk(got_fault == 3'd2, "R8 probe leaf invalid", 64'(got_fault), 2);
  endtask

  task automatic t_fault_on();
    walk(mkva(1, 1, 4), 1'b0, 3'b110);
    chk(got_fault == 3'd5, "R11 exec priority", 64'(got_fault), 5);
    walk(mkva(1, 1, 4), 1'b0, 3'b010);
    chk(got_fault == 3'd4, "R11 write fault", 64'(got_fault), 4);
    walk(mkva(1, 1, 4), 1'b0, 3'b001);
    chk(got_fault == 3'd3, "R11 read fault", 64'(got_fault), 3);
    walk(mkva(1, 1, 5), 1'b0, 3'b011);
    chk(got_fault == 3'd0 && got_prot == 3'b101, "R11 partial survive",
        64'({got_fault, got_prot}), 64'h5);
    walk(mkva(1, 1, 6), 1'b0, 3'b001);
    chk(got_fault == 3'd1, "R10 violation beats fault-on", 64'(got_fault), 1);
  endtask

  task automatic t_probe();
    walk(mkva(1, 1, 7), 1'b0, 3'b000);
    chk(got_fault == 3'd0 && got_prot == 3'b000, "R12 probe result",
        64'({got_fault, got_prot}), 0);
    chk(got_phys == page(32'h1007), "R12 probe phys", 64'(got_phys),
        64'(page(32'h1007)));
    walk(mkva(1, 1, 4), 1'b0, 3'b000);
    chk(got_fault == 3'd0 && got_prot == 3'b000 && got_phys == page(32'h1004),
        "R12 probe masked", 64'({got_fault, got_prot}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_vaddr = 64'd0;
    req_mode = 1'b0;
    req_need = 3'b000;
    req_tbase = TB0;
    // level 1 (base page 1)
    pmem[64'(TB0 + 8)]      = mkpte(32'd2, 16'h0101);
    pmem[64'(TB0 + 5 * 8)]  = mkpte(32'd4, 16'h0101);
    pmem[64'(TB0 + 6 * 8)]  = mkpte(32'd2, 16'h0201);
    // level 2 (base page 2)
    pmem[64'(page(2) + 8)]  = mkpte(32'd3, 16'h0101);
    // leaves (base page 3)
    pmem[64'(page(3) + 1 * 8)] = mkpte(32'h1001, 16'h0101);
    pmem[64'(page(3) + 3 * 8)] = mkpte(32'h1003, 16'h2201);
    pmem[64'(page(3) + 4 * 8)] = mkpte(32'h1004, 16'h110F);
    pmem[64'(page(3) + 5 * 8)] = mkpte(32'h1005, 16'h0105);
    pmem[64'(page(3) + 6 * 8)] = mkpte(32'h1006, 16'h0003);
    pmem[64'(page(3) + 7 * 8)] = mkpte(32'h1007, 16'h0001);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_noncanon();
    t_super();
    t_neg_walk();
    t_full_read();
    t_user_modes();
    t_dir_faults();
    t_leaf_invalid();
    t_fault_on();
    t_probe();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule